// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Day-Number Alarm

This core keeps wall-clock time for a system that already produces a one-pulse-per-second strobe. Seconds, minutes and hours are held as packed two-digit BCD bytes. The date is a plain 15-bit binary count of elapsed days, so software does its own date conversion. Each accepted strobe advances the seconds. A wrap of one field carries into the next, up to the day count.

Software reaches the core through a byte-wide register port. Writes take effect on the clock edge. Reads are combinational from the address. The core also holds an alarm made of a minute, an hour and a day number. Each of the three fields has its own enable. When the enabled fields start to agree with the running time, a sticky flag is raised. The flag can drive an interrupt line, and software clears it by writing 1 to it. A busy bit shows the single cycle in which the time fields are being advanced. A write that lands in that cycle is held back by one cycle so that it cannot collide with the update.

Top module: `cal_clock_core`

## Requirements
- R1: Seconds count in packed BCD (address 0x15) from 0x00 to 0x59. An increment from 0x59 gives 0x00 and carries into minutes, and an increment from a low digit of 9 (e.g. 0x09) gives the next tens value (0x10).
- R2: Minutes (0x16) count 0x00..0x59 and hours (0x17) count 0x00..0x23 in packed BCD. A wrap of hours increments the day count, so 23:59:59 followed by a strobe reads 00:00:00 on the next day.
- R3: The day count is 15-bit binary. Bits 7:0 are at 0x18 and bits 14:8 are at bits 6:0 of 0x19. Bit 7 of 0x19 always reads 0, and a value written to it is dropped. The count wraps from 0x7FFF to 0.
- R4: The control register is at 0x14. A strobe on `tick` is ignored unless control bit 0 (run) is 1.
- R5: An accepted strobe makes control bit 7 (busy) read 1 for exactly the next clock cycle. The time fields keep their old values during that cycle and show the advanced values from the cycle after it.
- R6: A write that arrives in the busy cycle is not lost. It takes effect one cycle later, after the advance, so the written value replaces the advanced one.
- R7: A write of a non-BCD or out-of-range byte is stored and read back unchanged. The next advance of that field wraps it to 0x00 and carries into the next field.
- R8: The alarm registers are minute 0x1A, hour 0x1B, day bits 7:0 at 0x1C and day bits 14:8 at 0x1D. The field enables are control bit 3 (minute), bit 4 (hour) and bit 5 (day). The alarm matches when at least one field is enabled and every enabled field equals the running time. Seconds never take part in the match.
- R9: Control bit 2 (alarm flag) is set on the advance that turns a non-matching time into a matching one. Further advances while the time still matches do not set it again after it has been cleared.
- R10: Writing the control register with bit 2 set clears the alarm flag. Writing it with bit 2 clear leaves the flag unchanged.
- R11: `alarm_irq` is high exactly when the alarm flag is set and control bit 1 (interrupt enable) is 1.
- R12: After reset, every register reads 0x00 and `alarm_irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe, one per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The assertions take two things for granted about the inputs. First, `tick` never stays high for two cycles in a row, so busy is always a single-cycle pulse. Second, a new write never arrives in a busy cycle while an earlier held write is still waiting, so the one-entry holding register never has to hold two writes. The bench meets both conditions. It raises `tick` for one cycle and then leaves it low for at least two. It spaces writes two cycles apart, with only one of them placed in a busy cycle, which is the held-write scenario.

// File: rtl/cal_clock_pkg.sv
`timescale 1ns/1ps
package cal_clock_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int DAY_W  = 15;
    localparam int DAY_HI_W = DAY_W - DATA_W;

    // byte addresses (decoded by software)
    localparam logic [ADDR_W-1:0] A_CTRL    = 8'h14;
    localparam logic [ADDR_W-1:0] A_SEC     = 8'h15;
    localparam logic [ADDR_W-1:0] A_MIN     = 8'h16;
    localparam logic [ADDR_W-1:0] A_HR      = 8'h17;
    localparam logic [ADDR_W-1:0] A_DAY_LO  = 8'h18;
    localparam logic [ADDR_W-1:0] A_DAY_HI  = 8'h19;
    localparam logic [ADDR_W-1:0] A_AMIN    = 8'h1A;
    localparam logic [ADDR_W-1:0] A_AHR     = 8'h1B;
    localparam logic [ADDR_W-1:0] A_ADAY_LO = 8'h1C;
    localparam logic [ADDR_W-1:0] A_ADAY_HI = 8'h1D;

    // control bit positions
    localparam int CB_RUN  = 0;
    localparam int CB_IEN  = 1;
    localparam int CB_FLAG = 2;
    localparam int CB_MEN  = 3;
    localparam int CB_HEN  = 4;
    localparam int CB_DEN  = 5;
    localparam int CB_BUSY = 7;

    localparam logic [DATA_W-1:0] SEC_TOP = 8'h59;
    localparam logic [DATA_W-1:0] MIN_TOP = 8'h59;
    localparam logic [DATA_W-1:0] HR_TOP  = 8'h23;

    typedef struct packed {
        logic [DATA_W-1:0] sec;
        logic [DATA_W-1:0] min;
        logic [DATA_W-1:0] hr;
        logic [DAY_W-1:0]  day;
    } tod_t;

    // fields that take part in alarm matching
    typedef struct packed {
        logic [DATA_W-1:0] min;
        logic [DATA_W-1:0] hr;
        logic [DAY_W-1:0]  day;
    } match_t;

    typedef struct packed {
        logic day_en;
        logic hr_en;
        logic min_en;
        logic irq_en;
        logic run;
    } cal_cfg_t;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    // One BCD step: returns {carry, next}. Anything at or above the top
    // value, or with a low digit above 9, wraps to zero with carry.
    function automatic logic [DATA_W:0] bcd_step(input logic [DATA_W-1:0] v,
                                                 input logic [DATA_W-1:0] top);
        logic [3:0] hi_n;
        logic [3:0] lo_n;
        hi_n = v[7:4] + 4'd1;
        lo_n = v[3:0] + 4'd1;
        if (v[3:0] > 4'd9 || v >= top)
            return {1'b1, 8'h00};
        else if (v[3:0] == 4'd9)
            return {1'b0, hi_n, 4'd0};
        else
            return {1'b0, v[7:4], lo_n};
    endfunction

endpackage

// File: rtl/cal_wr_hold.sv
`timescale 1ns/1ps
module cal_wr_hold
    import cal_clock_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    busy,
    input  wr_req_t in_req,
    output wr_req_t apply,
    output logic    pending
);
    wr_req_t hold_q;

    always_comb begin
        apply = '0;
        if (!busy)
            apply = hold_q.vld ? hold_q : in_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (busy) begin
            if (in_req.vld)
                hold_q <= in_req;
        end else if (hold_q.vld) begin
            // held write drains now; a same-cycle write takes its place
            hold_q <= in_req;
        end
    end

    assign pending = hold_q.vld;
endmodule

// File: rtl/cal_tod_counter.sv
`timescale 1ns/1ps
module cal_tod_counter
    import cal_clock_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    step,
    input  wr_req_t wr,
    output tod_t    cur,
    output tod_t    nxt
);
    logic [DATA_W:0] sec_s, min_s, hr_s;

    always_comb begin
        sec_s   = bcd_step(cur.sec, SEC_TOP);
        min_s   = bcd_step(cur.min, MIN_TOP);
        hr_s    = bcd_step(cur.hr,  HR_TOP);
        nxt     = cur;
        nxt.sec = sec_s[DATA_W-1:0];
        if (sec_s[DATA_W]) begin
            nxt.min = min_s[DATA_W-1:0];
            if (min_s[DATA_W]) begin
                nxt.hr = hr_s[DATA_W-1:0];
                if (hr_s[DATA_W])
                    nxt.day = cur.day + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (step) begin
            cur <= nxt;
        end else if (wr.vld) begin
            case (wr.addr)
                A_SEC:    cur.sec <= wr.data;
                A_MIN:    cur.min <= wr.data;
                A_HR:     cur.hr  <= wr.data;
                A_DAY_LO: cur.day[DATA_W-1:0] <= wr.data;
                A_DAY_HI: cur.day[DAY_W-1:DATA_W] <= wr.data[DAY_HI_W-1:0];
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/cal_alarm_unit.sv
`timescale 1ns/1ps
module cal_alarm_unit
    import cal_clock_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     step,
    input  wr_req_t  wr,
    input  match_t   now_t,
    input  match_t   next_t,
    output cal_cfg_t cfg,
    output match_t   alm,
    output logic     flag
);
    function automatic logic hit(input match_t t, input match_t a, input cal_cfg_t c);
        return (c.min_en | c.hr_en | c.day_en)
             & (!c.min_en | (t.min == a.min))
             & (!c.hr_en  | (t.hr  == a.hr))
             & (!c.day_en | (t.day == a.day));
    endfunction

    logic hit_now, hit_next;
    assign hit_now  = hit(now_t,  alm, cfg);
    assign hit_next = hit(next_t, alm, cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            alm  <= '0;
            flag <= 1'b0;
        end else begin
            if (wr.vld) begin
                case (wr.addr)
                    A_CTRL: begin
                        cfg.run    <= wr.data[CB_RUN];
                        cfg.irq_en <= wr.data[CB_IEN];
                        cfg.min_en <= wr.data[CB_MEN];
                        cfg.hr_en  <= wr.data[CB_HEN];
                        cfg.day_en <= wr.data[CB_DEN];
                        if (wr.data[CB_FLAG])
                            flag <= 1'b0;
                    end
                    A_AMIN:    alm.min <= wr.data;
                    A_AHR:     alm.hr  <= wr.data;
                    A_ADAY_LO: alm.day[DATA_W-1:0] <= wr.data;
                    A_ADAY_HI: alm.day[DAY_W-1:DATA_W] <= wr.data[DAY_HI_W-1:0];
                    default:   ;
                endcase
            end
            if (step && hit_next && !hit_now)
                flag <= 1'b1;
        end
    end
endmodule

// File: rtl/cal_clock_core.sv
`timescale 1ns/1ps
module cal_clock_core
    import cal_clock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              alarm_irq
);
    localparam int PAD_W = DATA_W - DAY_HI_W;

    logic     busy_q;
    wr_req_t  in_req, apply;
    logic     hold_pending;
    tod_t     tod_cur, tod_nxt;
    cal_cfg_t cfg;
    match_t   alm, now_m, next_m;
    logic     flag;

    always_ff @(posedge clk) begin
        if (rst) busy_q <= 1'b0;
        else     busy_q <= tick & cfg.run;
    end

    assign in_req = '{vld: wr_en, addr: addr, data: wr_data};

    cal_wr_hold u_hold (
        .clk(clk), .rst(rst), .busy(busy_q),
        .in_req(in_req), .apply(apply), .pending(hold_pending)
    );

    cal_tod_counter u_tod (
        .clk(clk), .rst(rst), .step(busy_q),
        .wr(apply), .cur(tod_cur), .nxt(tod_nxt)
    );

    assign now_m  = '{min: tod_cur.min, hr: tod_cur.hr, day: tod_cur.day};
    assign next_m = '{min: tod_nxt.min, hr: tod_nxt.hr, day: tod_nxt.day};

    cal_alarm_unit u_alm (
        .clk(clk), .rst(rst), .step(busy_q), .wr(apply),
        .now_t(now_m), .next_t(next_m),
        .cfg(cfg), .alm(alm), .flag(flag)
    );

    always_comb begin
        case (addr)
            A_CTRL:    rd_data = {busy_q, 1'b0, cfg.day_en, cfg.hr_en,
                                  cfg.min_en, flag, cfg.irq_en, cfg.run};
            A_SEC:     rd_data = tod_cur.sec;
            A_MIN:     rd_data = tod_cur.min;
            A_HR:      rd_data = tod_cur.hr;
            A_DAY_LO:  rd_data = tod_cur.day[DATA_W-1:0];
            A_DAY_HI:  rd_data = {{PAD_W{1'b0}}, tod_cur.day[DAY_W-1:DATA_W]};
            A_AMIN:    rd_data = alm.min;
            A_AHR:     rd_data = alm.hr;
            A_ADAY_LO: rd_data = alm.day[DATA_W-1:0];
            A_ADAY_HI: rd_data = {{PAD_W{1'b0}}, alm.day[DAY_W-1:DATA_W]};
            default:   rd_data = '0;
        endcase
    end

    assign alarm_irq = flag & cfg.irq_en;
endmodule

// File: rtl/cal_clock_chk.sv
`timescale 1ns/1ps
module cal_clock_chk
    import cal_clock_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              wr_en,
    input logic              apply_vld,
    input logic [ADDR_W-1:0] apply_addr,
    input logic [DATA_W-1:0] apply_data,
    input logic              pending,
    input logic              flag,
    input logic [DATA_W-1:0] sec,
    input logic [DATA_W-1:0] min,
    input logic [DATA_W-1:0] hr,
    input logic [DAY_W-1:0]  day
);
    // busy lasts a single cycle
    p_busy_single_r5: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // without an advance or a write the time does not move
    p_time_still_r4: assert property (@(posedge clk) disable iff (rst)
        (!busy && !apply_vld) |=> ($stable(sec) && $stable(min) && $stable(hr) && $stable(day)));

    // a write in the busy cycle is parked
    p_write_parked_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> pending);

    // flag rises only as a result of an advance
    p_flag_on_step_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(busy));

    // write-one clear
    p_flag_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && apply_vld && apply_addr == A_CTRL && apply_data[CB_FLAG]) |=> !flag);

    // full rollover of the day count
    p_day_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && day == {DAY_W{1'b1}} && hr == HR_TOP && min == MIN_TOP && sec == SEC_TOP)
        |=> (day == '0 && hr == 8'h00));
endmodule

bind cal_clock_core cal_clock_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy_q), .wr_en(wr_en),
    .apply_vld(apply.vld), .apply_addr(apply.addr), .apply_data(apply.data),
    .pending(hold_pending), .flag(flag),
    .sec(tod_cur.sec), .min(tod_cur.min), .hr(tod_cur.hr), .day(tod_cur.day)
);

// File: tb/sim_cal_clock_core.sv
`timescale 1ns/1ps
module sim_cal_clock_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       alarm_irq;

    int n_checks = 0;
    int n_errors = 0;

    cal_clock_core u0 (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .alarm_irq(alarm_irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m,
                            input logic [7:0] s, input logic [15:0] d);
        wr(8'h15, s); wr(8'h16, m); wr(8'h17, h);
        wr(8'h18, d[7:0]); wr(8'h19, d[15:8]);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 8'h14; a <= 8'h1D; a++) begin
            rd(a[7:0], v);
            check("R12", "reset register", {8'h00, v}, 16'h0000);
        end
        check("R12", "reset irq", {15'd0, alarm_irq}, 16'h0000);
    endtask

    task automatic t_run_gate();
        logic [7:0] v;
        wr(8'h14, 8'h00);
        pulse();
        rd(8'h15, v);
        check("R4", "no advance when stopped", {8'h00, v}, 16'h0000);
        rd(8'h14, v);
        check("R4", "no busy when stopped", {8'h00, v}, 16'h0000);
    endtask

    task automatic t_busy_step();
        logic [7:0] v;
        wr(8'h14, 8'h01);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        rd(8'h14, v);
        check("R5", "busy during advance", {8'h00, v}, 16'h0081);
        rd(8'h15, v);
        check("R5", "seconds unchanged while busy", {8'h00, v}, 16'h0000);
        @(negedge clk);
        rd(8'h15, v);
        check("R5", "seconds after advance", {8'h00, v}, 16'h0001);
        rd(8'h14, v);
        check("R5", "busy cleared", {8'h00, v}, 16'h0001);
    endtask

    task automatic t_bcd_digits();
        logic [7:0] v;
        set_time(8'h00, 8'h00, 8'h09, 16'h0000);
        pulse();
        rd(8'h15, v);
        check("R1", "09 -> 10", {8'h00, v}, 16'h0010);
        set_time(8'h00, 8'h12, 8'h59, 16'h0000);
        pulse();
        rd(8'h15, v);
        check("R1", "59 wraps", {8'h00, v}, 16'h0000);
        rd(8'h16, v);
        check("R1", "carry into minutes", {8'h00, v}, 16'h0013);
    endtask

    task automatic t_rollover();
        logic [7:0] v;
        set_time(8'h23, 8'h59, 8'h59, 16'h0123);
        pulse();
        rd(8'h17, v);
        check("R2", "hour wraps", {8'h00, v}, 16'h0000);
        rd(8'h16, v);
        check("R2", "minute wraps", {8'h00, v}, 16'h0000);
        rd(8'h18, v);
        check("R2", "day low increments", {8'h00, v}, 16'h0024);
        rd(8'h19, v);
        check("R2", "day high kept", {8'h00, v}, 16'h0001);
    endtask

    task automatic t_day_wrap();
        logic [7:0] v;
        set_time(8'h23, 8'h59, 8'h59, 16'hFFFF);
        rd(8'h19, v);
        check("R3", "day high bit 7 dropped", {8'h00, v}, 16'h007F);
        pulse();
        rd(8'h18, v);
        check("R3", "day low after wrap", {8'h00, v}, 16'h0000);
        rd(8'h19, v);
        check("R3", "day high after wrap", {8'h00, v}, 16'h0000);
    endtask

    task automatic t_non_bcd();
        logic [7:0] v;
        set_time(8'h3F, 8'h07, 8'h5A, 16'h0005);
        rd(8'h17, v);
        check("R7", "out-of-range hour stored", {8'h00, v}, 16'h003F);
        rd(8'h15, v);
        check("R7", "non-BCD seconds stored", {8'h00, v}, 16'h005A);
        pulse();
        rd(8'h15, v);
        check("R7", "non-BCD seconds wrap", {8'h00, v}, 16'h0000);
        rd(8'h16, v);
        check("R7", "carry from non-BCD seconds", {8'h00, v}, 16'h0008);
        set_time(8'h3F, 8'h59, 8'h59, 16'h0005);
        pulse();
        rd(8'h17, v);
        check("R7", "bad hour wraps", {8'h00, v}, 16'h0000);
        rd(8'h18, v);
        check("R7", "bad hour carries into day", {8'h00, v}, 16'h0006);
    endtask

    task automatic t_alarm_main();
        logic [7:0] v;
        wr(8'h14, 8'h05);
        wr(8'h1A, 8'h05); wr(8'h1B, 8'h10); wr(8'h1C, 8'h02); wr(8'h1D, 8'h00);
        set_time(8'h10, 8'h04, 8'h59, 16'h0002);
        wr(8'h14, 8'h3F);
        check("R11", "irq low before match", {15'd0, alarm_irq}, 16'h0000);
        pulse();
        rd(8'h14, v);
        check("R9", "flag set on match", {8'h00, v}, 16'h003F);
        check("R11", "irq high with flag and enable", {15'd0, alarm_irq}, 16'h0001);
        pulse();
        wr(8'h14, 8'h3B);
        rd(8'h14, v);
        check("R10", "write 0 keeps flag", {8'h00, v}, 16'h003F);
        wr(8'h14, 8'h3F);
        rd(8'h14, v);
        check("R10", "write 1 clears flag", {8'h00, v}, 16'h003B);
        check("R11", "irq low after clear", {15'd0, alarm_irq}, 16'h0000);
        pulse();
        rd(8'h14, v);
        check("R9", "no refire inside matching minute", {8'h00, v}, 16'h003B);
    endtask

    task automatic t_alarm_fields();
        logic [7:0] v;
        wr(8'h14, 8'h3F);
        set_time(8'h10, 8'h04, 8'h59, 16'h0003);
        pulse();
        rd(8'h14, v);
        check("R8", "day mismatch blocks alarm", {8'h00, v}, 16'h003B);
        wr(8'h14, 8'h0F);
        set_time(8'h10, 8'h04, 8'h59, 16'h0003);
        pulse();
        rd(8'h14, v);
        check("R8", "minute-only match fires", {8'h00, v}, 16'h000F);
        wr(8'h14, 8'h07);
        set_time(8'h10, 8'h04, 8'h59, 16'h0002);
        pulse();
        rd(8'h14, v);
        check("R8", "no field enabled never fires", {8'h00, v}, 16'h0003);
        wr(8'h14, 8'h3D);
        set_time(8'h10, 8'h04, 8'h59, 16'h0002);
        pulse();
        rd(8'h14, v);
        check("R11", "flag set with interrupt off", {8'h00, v}, 16'h003D);
        check("R11", "irq held low when disabled", {15'd0, alarm_irq}, 16'h0000);
    endtask

    task automatic t_write_held();
        logic [7:0] v;
        wr(8'h14, 8'h05);
        wr(8'h15, 8'h20);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        wr_en = 1'b1; addr = 8'h15; wr_data = 8'h45;
        @(negedge clk);
        wr_en = 1'b0;
        rd(8'h15, v);
        check("R6", "advance first", {8'h00, v}, 16'h0021);
        @(negedge clk);
        rd(8'h15, v);
        check("R6", "held write applied", {8'h00, v}, 16'h0045);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_run_gate();
        t_busy_step();
        t_bcd_digits();
        t_rollover();
        t_day_wrap();
        t_non_bcd();
        t_alarm_main();
        t_alarm_fields();
        t_write_held();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule